// File: doc/BRIEF.md
# Stochastic Random-Sign Weight Updater

This block performs the on-chip learning step for the input weights of one hidden neuron, working on 64 weights in a single cycle. A software-loadable sign table holds one fixed random bit for every pair of hidden neuron and class. The training label, together with the neuron index, picks one bit from that table. The bit fixes whether all 64 weights of the beat move up or down. Each weight then moves one step with a probability set by its input activation magnitude. That probability is compared against a fresh 12-bit random number for every lane, and all 768 random bits come from one 20-bit shift-register generator that is advanced many steps per cycle. A configurable shift scales the probability and so acts as the learning rate.

The caller reads the current 8-bit weights of the beat from its weight store and presents them together with the activations, the neuron index, the label and the neuron's binary activation derivative. One cycle later the block returns the updated weights, which the caller writes back. The weight store is cleared to zero before training starts. The block sees only the beat it is given, so weight-store timing and the forward pass stay outside it.

Top module: `rpw_updater`

## Requirements
- R1: The sign table has 128 entries of 10 bits, one bit per class, and resets to all zero. When `cfg_we` is high at a clock edge, entry `cfg_addr` takes `cfg_wdata`. `cfg_rdata` shows entry `cfg_addr` without a clock delay.
- R2: The direction bit is bit `upd_label` of table entry `upd_neuron`. When it is 0, a selected weight is incremented by one. When it is 1, a selected weight is decremented by one.
- R3: Weights pass through unchanged when `upd_grad` is 0, or when `upd_label` is 10 or more.
- R4: A lane whose activation is zero never changes its weight, whatever the learning rate and the random value.
- R5: Lane j steps when (activation_j << `lr_shift`), taken as a 13-bit unsigned value, is strictly greater than the lane's 12-bit random value. Otherwise the weight holds. A weight never changes by more than one.
- R6: The generator is 20 bits wide and resets to state 1. Its bit stream b starts as b[i] = state[i] for i in 0..19, and b[k] = b[k-20] XOR b[k-17] for higher k. Lane j uses random value bit m = b[12j+m]. On every cycle with `upd_valid` high, the state becomes b[768..787]. In all other cycles the state is held.
- R7: Weights are two's complement and saturate. +127 does not increment and -128 does not decrement.
- R8: `out_valid` is high exactly in the cycle after a cycle with `upd_valid` high. In that cycle `out_w` holds the result for that beat. Lane j uses bits [8j+7:8j] of the weight buses and bits [6j+5:6j] of `upd_act`.
- R9: After reset, `out_valid` is 0 and `out_w` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Sign-table write strobe |
| cfg_addr | input | 7 | Sign-table entry for write and read |
| cfg_wdata | input | 10 | Entry write data, one bit per class |
| cfg_rdata | output | 10 | Entry read data |
| lr_shift | input | 3 | Learning-rate left shift applied to activations |
| upd_valid | input | 1 | Update beat present |
| upd_neuron | input | 7 | Hidden-neuron index of the beat |
| upd_label | input | 4 | Training label |
| upd_grad | input | 1 | Binary activation derivative of the neuron |
| upd_act | input | 384 | 64 unsigned 6-bit input activations |
| upd_w | input | 512 | 64 current signed 8-bit weights |
| out_valid | output | 1 | Updated beat present |
| out_w | output | 512 | 64 updated signed 8-bit weights |

## Verification
Full-scale activations with the widest shift force every lane to step, so the all-up and all-down table entries show the direction choice by itself. A mixed-bit entry read with two labels shows that the label really selects the bit. Zeroed derivative, out-of-range labels and zeroed lanes must all pass weights through unchanged. Weights at the signed limits, and one below them, tell saturation apart from wrap-around. Random activations, weights and shifts run back to back and are checked bit-exactly against an independent model of the generator stream. This catches any error in stream order, lane slicing, strict comparison or advance rule.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/rpw_sign_table.sv
module rpw_sign_table #(
  parameter int N_NEURON = 128,
  parameter int N_CLASS  = 10,
  localparam int IDX_W   = $clog2(N_NEURON),
  localparam int LBL_W   = $clog2(N_CLASS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   addr,
  input  logic [N_CLASS-1:0] wr_data,
  output logic [N_CLASS-1:0] rd_data,
  input  logic [IDX_W-1:0]   sel_neuron,
  input  logic [LBL_W-1:0]   sel_label,
  output logic               sel_ok,
  output logic               sel_bit
);
  logic [N_CLASS-1:0] ent_q [N_NEURON];
  logic [N_CLASS-1:0] sel_row;
  logic               addr_ok;

  always_comb begin
    addr_ok = int'(addr) < N_NEURON;
    rd_data = addr_ok ? ent_q[addr] : '0;
    sel_row = (int'(sel_neuron) < N_NEURON) ? ent_q[sel_neuron] : '0;
    sel_ok  = int'(sel_label) < N_CLASS;
    sel_bit = sel_ok ? sel_row[sel_label] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_NEURON; i++) ent_q[i] <= '0;
    end else if (wr_en && addr_ok) begin
      ent_q[addr] <= wr_data;
    end
  end

  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_ok) |=> (ent_q[$past(addr)] == $past(wr_data))) // R1
    else $error("sign table write lost");
endmodule

// File: rtl/rpw_lfsr_unfold.sv
module rpw_lfsr_unfold #(
  parameter int                STATE_W  = 20,
  parameter int                TAP      = 3,
  parameter int                OUT_BITS = 768,
  parameter logic [STATE_W-1:0] SEED    = STATE_W'(1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [OUT_BITS-1:0] bits_o
);
  logic [STATE_W-1:0] state_q, state_d, win;

  always_comb begin
    win = state_q;
    for (int k = 0; k < OUT_BITS; k++) begin
      bits_o[k] = win[0];
      win       = {win[0] ^ win[TAP], win[STATE_W-1:1]};
    end
    state_d = adv ? win : state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0) // R6
    else $error("generator locked at zero");
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state_q)) // R6
    else $error("generator moved without advance");
endmodule

// File: rtl/rpw_lane.sv
module rpw_lane
  import rpw_pkg::*;
#(
  parameter int W_BITS   = 8,
  parameter int ACT_BITS = 6,
  parameter int RND_BITS = 12,
  parameter int LR_BITS  = 3
) (
  input  logic [ACT_BITS-1:0] act_i,
  input  logic [W_BITS-1:0]   w_i,
  input  logic [RND_BITS-1:0] rnd_i,
  input  logic [LR_BITS-1:0]  lr_i,
  input  logic                en_i,
  input  logic                down_i,
  output logic [W_BITS-1:0]   w_o
);
  localparam int SC_W = ACT_BITS + (1 << LR_BITS) - 1;
  localparam logic [W_BITS-1:0] W_MAX = {1'b0, {(W_BITS-1){1'b1}}};
  localparam logic [W_BITS-1:0] W_MIN = {1'b1, {(W_BITS-1){1'b0}}};

  logic [SC_W-1:0] scaled;
  logic            hit;
  step_e           step;

  always_comb begin
    scaled = SC_W'(act_i) << lr_i;
    hit    = en_i && (scaled > SC_W'(rnd_i));
    if (!hit)       step = STEP_HOLD;
    else if (down_i) step = STEP_DOWN;
    else            step = STEP_UP;
    w_o = w_i;
    case (step)
      STEP_UP:   if (w_i != W_MAX) w_o = w_i + W_BITS'(1);
      STEP_DOWN: if (w_i != W_MIN) w_o = w_i - W_BITS'(1);
      default:   w_o = w_i;
    endcase
  end
endmodule

// File: rtl/rpw_updater.sv
module rpw_updater #(
  parameter int N_NEURON = 128,
  parameter int N_CLASS  = 10,
  parameter int LANES    = 64,
  parameter int W_BITS   = 8,
  parameter int ACT_BITS = 6,
  parameter int RND_BITS = 12,
  parameter int LR_BITS  = 3,
  parameter int LFSR_W   = 20,
  parameter int LFSR_TAP = 3,
  parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(1),
  localparam int IDX_W   = $clog2(N_NEURON),
  localparam int LBL_W   = $clog2(N_CLASS),
  localparam int RBITS   = LANES * RND_BITS,
  localparam int WBUS    = LANES * W_BITS,
  localparam int ABUS    = LANES * ACT_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [N_CLASS-1:0] cfg_wdata,
  output logic [N_CLASS-1:0] cfg_rdata,
  input  logic [LR_BITS-1:0] lr_shift,
  input  logic               upd_valid,
  input  logic [IDX_W-1:0]   upd_neuron,
  input  logic [LBL_W-1:0]   upd_label,
  input  logic               upd_grad,
  input  logic [ABUS-1:0]    upd_act,
  input  logic [WBUS-1:0]    upd_w,
  output logic               out_valid,
  output logic [WBUS-1:0]    out_w
);
  localparam logic [W_BITS-1:0] W_MAX = {1'b0, {(W_BITS-1){1'b1}}};
  localparam logic [W_BITS-1:0] W_MIN = {1'b1, {(W_BITS-1){1'b0}}};

  logic             rst_meta, rst_sync;
  logic             sel_ok, sel_bit, lane_en;
  logic [RBITS-1:0] rnd_bits;
  logic [WBUS-1:0]  w_next, w_d;
  logic             valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  rpw_sign_table #(.N_NEURON(N_NEURON), .N_CLASS(N_CLASS)) u_table (
    .clk(clk), .rst_n(rst_sync), .wr_en(cfg_we), .addr(cfg_addr),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .sel_neuron(upd_neuron),
    .sel_label(upd_label), .sel_ok(sel_ok), .sel_bit(sel_bit)
  );

  rpw_lfsr_unfold #(.STATE_W(LFSR_W), .TAP(LFSR_TAP), .OUT_BITS(RBITS),
                    .SEED(LFSR_SEED)) u_rng (
    .clk(clk), .rst_n(rst_sync), .adv(upd_valid), .bits_o(rnd_bits)
  );

  assign lane_en = upd_grad && sel_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rpw_lane #(.W_BITS(W_BITS), .ACT_BITS(ACT_BITS), .RND_BITS(RND_BITS),
               .LR_BITS(LR_BITS)) u_lane (
      .act_i (upd_act[g*ACT_BITS +: ACT_BITS]),
      .w_i   (upd_w[g*W_BITS +: W_BITS]),
      .rnd_i (rnd_bits[g*RND_BITS +: RND_BITS]),
      .lr_i  (lr_shift),
      .en_i  (lane_en),
      .down_i(sel_bit),
      .w_o   (w_next[g*W_BITS +: W_BITS])
    );

    AST_NO_GRAD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
      (upd_valid && !upd_grad) |=>
      (out_w[g*W_BITS +: W_BITS] == $past(upd_w[g*W_BITS +: W_BITS]))) // R3
      else $error("weight changed without derivative");
    AST_ZERO_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
      (upd_valid && (upd_act[g*ACT_BITS +: ACT_BITS] == '0)) |=>
      (out_w[g*W_BITS +: W_BITS] == $past(upd_w[g*W_BITS +: W_BITS]))) // R4
      else $error("zero activation moved weight");
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_sync)
      upd_valid |=>
      ((out_w[g*W_BITS +: W_BITS] == $past(upd_w[g*W_BITS +: W_BITS])) ||
       (out_w[g*W_BITS +: W_BITS] == $past(upd_w[g*W_BITS +: W_BITS]) + W_BITS'(1)) ||
       (out_w[g*W_BITS +: W_BITS] == $past(upd_w[g*W_BITS +: W_BITS]) - W_BITS'(1)))) // R5
      else $error("weight step larger than one");
    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_sync)
      (upd_valid && (upd_w[g*W_BITS +: W_BITS] == W_MAX)) |=>
      (out_w[g*W_BITS +: W_BITS] != W_MIN)) // R7
      else $error("weight wrapped past maximum");
    AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_sync)
      (upd_valid && (upd_w[g*W_BITS +: W_BITS] == W_MIN)) |=>
      (out_w[g*W_BITS +: W_BITS] != W_MAX)) // R7
      else $error("weight wrapped past minimum");
  end

  always_comb begin
    valid_d = upd_valid;
    w_d     = upd_valid ? w_next : out_w;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      out_valid <= 1'b0;
      out_w     <= '0;
    end else begin
      out_valid <= valid_d;
      out_w     <= w_d;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_sync)
    upd_valid |=> out_valid) // R8
    else $error("result beat missing");
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
    !upd_valid |=> !out_valid) // R8
    else $error("spurious result beat");
endmodule

// File: tb/rpw_updater_bench.sv
module rpw_updater_bench;
  localparam int LANES = 64;
  localparam int WB    = LANES * 8;
  localparam int AB    = LANES * 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [6:0]    cfg_addr;
  logic [9:0]    cfg_wdata;
  logic [9:0]    cfg_rdata;
  logic [2:0]    lr_shift;
  logic          upd_valid;
  logic [6:0]    upd_neuron;
  logic [3:0]    upd_label;
  logic          upd_grad;
  logic [AB-1:0] upd_act;
  logic [WB-1:0] upd_w;
  logic          out_valid;
  logic [WB-1:0] out_w;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 0;
  bit done   = 0;

  logic [9:0]    tbl [128];
  logic [19:0]   gen_m;
  logic [WB-1:0] exp_q [$];
  string         tag_q [$];

  always #5ns clk = ~clk;

  rpw_updater u_rpw_updater (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lr_shift(lr_shift),
    .upd_valid(upd_valid), .upd_neuron(upd_neuron), .upd_label(upd_label),
    .upd_grad(upd_grad), .upd_act(upd_act), .upd_w(upd_w),
    .out_valid(out_valid), .out_w(out_w)
  );

  function automatic void check(input bit ok, input string req,
                                input logic [WB-1:0] act, input logic [WB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // Expected result from R2..R7, independent of the design's structure.
  function automatic logic [WB-1:0] model(input int nrn, input int lbl, input bit grad,
                                          input logic [AB-1:0] act,
                                          input logic [WB-1:0] w, input int lr);
    logic [WB-1:0]  res;
    logic [767:0]   b;
    logic [19:0]    win;
    win = gen_m;
    for (int k = 0; k < 768; k++) begin
      b[k] = win[0];
      win  = {win[0] ^ win[3], win[19:1]};
    end
    gen_m = win;
    res = w;
    for (int j = 0; j < LANES; j++) begin
      int a, r, sc, wv;
      a  = int'(act[6*j +: 6]);
      r  = int'(b[12*j +: 12]);
      sc = (a << lr) & 13'h1fff;
      wv = int'($signed(w[8*j +: 8]));
      if (grad && lbl < 10 && sc > r) begin
        if (tbl[nrn][lbl]) begin
          if (wv > -128) wv = wv - 1;
        end else begin
          if (wv < 127) wv = wv + 1;
        end
      end
      res[8*j +: 8] = 8'(wv);
    end
    return res;
  endfunction

  task automatic drive(input int nrn, input int lbl, input bit grad,
                       input logic [AB-1:0] act, input logic [WB-1:0] w,
                       input int lr, input string tag);
    @(negedge clk);
    upd_valid  = 1'b1;
    upd_neuron = 7'(nrn);
    upd_label  = 4'(lbl);
    upd_grad   = grad;
    upd_act    = act;
    upd_w      = w;
    lr_shift   = 3'(lr);
    exp_q.push_back(model(nrn, lbl, grad, act, w, lr));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic cfg_write(input int addr, input logic [9:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(addr); cfg_wdata = data;
    tbl[addr] = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input int addr);
    @(negedge clk);
    cfg_addr = 7'(addr);
    #1;
    check(cfg_rdata === tbl[addr], "R1 table readback", WB'(cfg_rdata), WB'(tbl[addr]));
  endtask

  // Scoreboard monitor, sampled 2 ns after the rising edge.
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      bit pend;
      pend = exp_q.size() > 0;
      check(out_valid === pend, "R8 out_valid timing", WB'(out_valid), WB'(pend));
      if (pend && out_valid === 1'b1) begin
        logic [WB-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_w === e, t, out_w, e);
      end
    end
  end

  function automatic logic [AB-1:0] fill_act(input int v);
    logic [AB-1:0] r;
    for (int j = 0; j < LANES; j++) r[6*j +: 6] = 6'(v);
    return r;
  endfunction

  function automatic logic [WB-1:0] fill_w(input int v);
    logic [WB-1:0] r;
    for (int j = 0; j < LANES; j++) r[8*j +: 8] = 8'(v);
    return r;
  endfunction

  initial begin
    logic [AB-1:0] a;
    logic [WB-1:0] w;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; lr_shift = '0;
    upd_valid = 1'b0; upd_neuron = '0; upd_label = '0; upd_grad = 1'b0;
    upd_act = '0; upd_w = '0;
    for (int i = 0; i < 128; i++) tbl[i] = '0;
    gen_m = 20'h00001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state, R1 table reset
    check(out_valid === 1'b0, "R9 out_valid after reset", WB'(out_valid), '0);
    check(out_w === '0, "R9 out_w after reset", out_w, '0);
    cfg_check(0);
    cfg_check(127);
    mon_en = 1;

    // R1 writes and readback
    cfg_write(5, 10'h000);
    cfg_write(6, 10'h3ff);
    cfg_write(7, 10'b00_0010_0000);
    cfg_write(127, 10'h155);
    cfg_check(6);
    cfg_check(7);
    cfg_check(127);
    cfg_check(5);

    // R2/R5 full-scale activations: every lane must step
    drive(5, 3, 1, fill_act(63), fill_w(0), 7, "R2 all up");
    drive(6, 9, 1, fill_act(63), fill_w(0), 7, "R2 all down");
    drive(7, 5, 1, fill_act(63), fill_w(10), 7, "R2 label bit set");
    drive(7, 4, 1, fill_act(63), fill_w(10), 7, "R2 label bit clear");
    // R3 derivative off and label out of range
    drive(6, 2, 0, fill_act(63), fill_w(33), 7, "R3 grad zero");
    drive(5, 12, 1, fill_act(63), fill_w(-7), 7, "R3 label out of range");
    drive(6, 15, 1, fill_act(63), fill_w(90), 7, "R3 label fifteen");
    // R4 zero activations on even lanes
    a = fill_act(63);
    for (int j = 0; j < LANES; j += 2) a[6*j +: 6] = '0;
    drive(6, 0, 1, a, fill_w(-20), 7, "R4 zero lanes hold");
    drive(5, 0, 1, fill_act(0), fill_w(4), 7, "R4 all zero");
    // R7 saturation and one-below limits
    drive(5, 1, 1, fill_act(63), fill_w(127), 7, "R7 top saturate");
    drive(6, 1, 1, fill_act(63), fill_w(-128), 7, "R7 bottom saturate");
    drive(5, 1, 1, fill_act(63), fill_w(126), 7, "R7 reach top");
    drive(6, 1, 1, fill_act(63), fill_w(-127), 7, "R7 reach bottom");
    idle();
    idle();

    // R5/R6 random patterns, back to back, exact stream model
    for (int it = 0; it < 48; it++) begin
      int nrn;
      for (int j = 0; j < LANES; j++) begin
        a[6*j +: 6] = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom_range(1, 63));
        w[8*j +: 8] = 8'($urandom);
      end
      nrn = (it % 4 == 0) ? 127 : (5 + it % 3);
      drive(nrn, $urandom_range(0, 9), 1, a, w, it % 8, "R5 R6 random stochastic");
      if (it % 6 == 5) idle();
    end
    idle();
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule